// File: doc/BRIEF.md
# Clocked Serial Shift Interface

This block moves one byte at a time over a synchronous serial link made of a clock pin, a data-out pin and a data-in pin. It can own the serial clock (master), producing it from a programmable divider of the system clock, or follow a clock from the far end (slave), which it passes through a two-flop synchronizer before finding edges. Each transfer is eight bits, most significant bit first. One bit of data leaves and one arrives in each clock cell. A configuration bit picks which edge of the serial clock launches outgoing data; incoming data is always sampled on the other edge.

The data can use three wires, with separate output and input pins, or two wires, where the data-out pin is shared. In two-wire mode a direction bit turns the shared pin into a driver (transmit) or a receiver. In either case incoming bits are taken from the shared pin, and the dedicated input pin is left to other uses. After the last bit the transmitter keeps that bit on the pin for one full bit period, measured with the internal divider even as a slave. It then returns the data line high and gives a one-cycle done pulse. Clearing both pin-function enables aborts a transfer at once. An abort clears only the busy flags and raises no done pulse.

The controller has four states. ST_IDLE waits for a write. ST_SHIFT moves the eight bits. ST_TAIL waits for the closing rising clock edge when the last sample fell on a falling edge. ST_HOLD times the last-bit hold. The transitions are:
- start: ST_IDLE to ST_SHIFT, on an accepted write.
- last_rise: ST_SHIFT to ST_HOLD, on the eighth sample when sampling is on rising edges.
- last_fall: ST_SHIFT to ST_TAIL, on the eighth sample when sampling is on falling edges.
- close: ST_TAIL to ST_HOLD, on the next rising edge.
- hold_end: ST_HOLD to ST_IDLE, when the hold counter expires.
- abort: any state to ST_IDLE, when both enables are low.

Top module: `ssi_shift_unit`

## Requirements
- R1: After reset the outputs read as follows. busy, bus_busy and done are 0, sclk_out is 1, sdo_out is 1 and rx_data is 0.
- R2: A write to an idle, enabled unit sends wr_data MSB first on sdo_out and collects eight received bits MSB first. When the eighth bit is sampled, those bits are loaded into rx_data.
- R3: With cfg_edge_sel = 0, data changes after a falling serial clock edge and is sampled on the rising edge. With cfg_edge_sel = 1 the two edges are swapped. sdo_out never changes at a sample edge.
- R4: As master, sclk_out idles at 1. In a transfer it gives exactly eight low-going pulses, and each half period lasts cfg_div + 1 system clocks.
- R5: The hold starts at the last rising serial clock edge of a transfer. It lasts 2*(cfg_div+1) system clocks, during which busy = 1, bus_busy = 0 and sdo_out keeps the last bit (wr_data bit 0). After the hold, sdo_out is 1.
- R6: done is high for exactly one cycle per completed transfer, in the first cycle that busy reads 0.
- R7: In three-wire mode (cfg_two_wire = 0) received bits come from sdi_in. In two-wire mode sdi_in has no effect on rx_data.
- R8: In two-wire mode with cfg_shared_tx = 1, sdo_oe is 1 and the unit receives the bits present on sdo_in. With cfg_shared_tx = 0, sdo_oe is 0 and received bits come from sdo_in.
- R9: While cfg_out_en and cfg_in_en are both 0, the unit aborts within one cycle. busy and bus_busy go to 0, sclk_out goes to 1 and sdo_oe goes to 0. No done pulse follows and rx_data keeps its value.
- R10: A write that arrives while busy = 1, or while both enables are 0, is ignored.
- R11: As slave (cfg_master = 0), the unit shifts on the edges of sclk_in with the same edge rules. The last-bit hold is still 2*(cfg_div+1) system clocks.
- R12: bus_busy is 1 from the cycle after an accepted write until the last rising serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: unit generates the serial clock |
| cfg_out_en | input | 1 | Output-pin function enable |
| cfg_in_en | input | 1 | Input-pin function enable |
| cfg_two_wire | input | 1 | 1: receive from the shared data pin |
| cfg_shared_tx | input | 1 | Two-wire direction, 1 = transmit |
| cfg_edge_sel | input | 1 | 0: launch on fall, sample on rise; 1: swapped |
| cfg_div | input | DIV_W | Half period of master clock minus one |
| wr_stb | input | 1 | Write strobe, starts a transfer |
| wr_data | input | DATA_W | Byte to send |
| sclk_in | input | 1 | External serial clock (slave) |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Clock pin drive enable |
| sdo_in | input | 1 | Pad value of the data-out pin |
| sdo_out | output | 1 | Data-out pin value |
| sdo_oe | output | 1 | Data-out pin drive enable |
| sdi_in | input | 1 | Dedicated data-in pin |
| busy | output | 1 | Transfer in progress, including the hold |
| bus_busy | output | 1 | Serial clock activity in progress |
| rx_data | output | DATA_W | Last received byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is the hold window in slave mode when sampling is on the falling edge. There the unit sits in ST_TAIL until the synchronized rising edge arrives, and only then counts the hold. The bench reaches it by driving sclk_in itself, with a half period much longer than the synchronizer delay. It acts as the far-end peer on every edge and counts the cycles where busy is high and bus_busy is low. A forced abort partway through a master transfer is the other hard case. A write strobe raised during a transfer and one raised while aborted cover the ignored-write paths.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2,
        ST_HOLD  = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/ssi_clkgen.sv
module ssi_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise_ev,
    output logic             fall_ev
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick    = run && (cnt_q == div);
    assign fall_ev = tick && sclk;
    assign rise_ev = tick && !sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b1;
        end else if (!run) begin
            cnt_q <= '0;
            sclk  <= 1'b1;
        end else if (tick) begin
            cnt_q <= '0;
            sclk  <= !sclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: clock returns to its idle level whenever the generator is stopped
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sclk);
endmodule

// File: rtl/ssi_edgesync.sv
module ssi_edgesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic rise_ev,
    output logic fall_ev
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], sclk_in};
        end
    end

    assign rise_ev = chain_q[STAGES-1] && !chain_q[STAGES];
    assign fall_ev = !chain_q[STAGES-1] && chain_q[STAGES];
endmodule

// File: rtl/ssi_engine.sv
module ssi_engine
    import ssi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] start_data,
    input  logic              abort,
    input  logic              edge_sel,
    input  logic [DIV_W-1:0]  div,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              rx_bit,
    output logic              busy,
    output logic              bus_busy,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_data,
    output logic              done
);
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int HOLD_W = DIV_W + 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    xfer_state_e       state_q, state_d;
    logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              pend_q;
    logic [HOLD_W-1:0] hold_cnt_q;
    logic [HOLD_W-1:0] hold_last;
    logic              sample_ev, launch_ev, last_sample, hold_end;
    logic [DATA_W-1:0] rx_next;

    assign sample_ev   = edge_sel ? fall_ev : rise_ev;
    assign launch_ev   = edge_sel ? rise_ev : fall_ev;
    assign last_sample = (state_q == ST_SHIFT) && sample_ev && (bit_cnt_q == LAST_IDX);
    assign hold_last   = {div, 1'b1};
    assign hold_end    = (state_q == ST_HOLD) && (hold_cnt_q == hold_last);
    assign rx_next     = {rx_sh_q[DATA_W-2:0], rx_bit};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)       state_d = ST_SHIFT;
            ST_SHIFT: if (last_sample) state_d = edge_sel ? ST_TAIL : ST_HOLD;
            ST_TAIL:  if (rise_ev)     state_d = ST_HOLD;
            ST_HOLD:  if (hold_end)    state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q    <= '0;
            rx_sh_q    <= '0;
            bit_cnt_q  <= '0;
            pend_q     <= 1'b0;
            hold_cnt_q <= '0;
            rx_data    <= '0;
            done       <= 1'b0;
        end else begin
            done <= hold_end && !abort;
            if (state_q == ST_HOLD) hold_cnt_q <= hold_cnt_q + 1'b1;
            else                    hold_cnt_q <= '0;
            if (state_q == ST_IDLE && start && !abort) begin
                tx_sh_q   <= start_data;
                bit_cnt_q <= '0;
                pend_q    <= 1'b0;
            end
            if (state_q == ST_SHIFT && !abort) begin
                if (sample_ev) begin
                    rx_sh_q   <= rx_next;
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                    pend_q    <= !last_sample;
                    if (last_sample) rx_data <= rx_next;
                end else if (launch_ev && pend_q) begin
                    tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b1};
                    pend_q  <= 1'b0;
                end
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign bus_busy = (state_q == ST_SHIFT) || (state_q == ST_TAIL);
    assign tx_bit   = (state_q == ST_IDLE) ? 1'b1 : tx_sh_q[DATA_W-1];

    // R6: completion pulse lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: pulse only after a hold that ran out
    a_r6_done_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(state_q == ST_HOLD)));
    // R9: abort empties the controller and suppresses completion
    a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !bus_busy && !done));
    // R5: last bit does not move during the hold
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q == ST_HOLD)) |-> $stable(tx_bit));
    // R12: accepted write raises bus activity
    a_r12_bus_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !abort) |=> bus_busy);
endmodule

// File: rtl/ssi_shift_unit.sv
module ssi_shift_unit #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_out_en,
    input  logic              cfg_in_en,
    input  logic              cfg_two_wire,
    input  logic              cfg_shared_tx,
    input  logic              cfg_edge_sel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdo_in,
    output logic              sdo_out,
    output logic              sdo_oe,
    input  logic              sdi_in,
    output logic              busy,
    output logic              bus_busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              done
);
    logic abort, run;
    logic g_rise, g_fall, s_rise, s_fall, rise_ev, fall_ev;
    logic rx_bit, tx_bit;

    assign abort = !cfg_out_en && !cfg_in_en;
    assign run   = cfg_master && bus_busy && !abort;

    ssi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div),
        .sclk(sclk_out), .rise_ev(g_rise), .fall_ev(g_fall)
    );

    ssi_edgesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in),
        .rise_ev(s_rise), .fall_ev(s_fall)
    );

    assign rise_ev = cfg_master ? g_rise : s_rise;
    assign fall_ev = cfg_master ? g_fall : s_fall;

    always_comb begin
        if (abort)             rx_bit = 1'b1;
        else if (cfg_two_wire) rx_bit = sdo_in;
        else if (cfg_in_en)    rx_bit = sdi_in;
        else                   rx_bit = 1'b1;
    end

    ssi_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(wr_stb), .start_data(wr_data),
        .abort(abort), .edge_sel(cfg_edge_sel), .div(cfg_div),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .rx_bit(rx_bit),
        .busy(busy), .bus_busy(bus_busy), .tx_bit(tx_bit),
        .rx_data(rx_data), .done(done)
    );

    assign sdo_out = tx_bit;
    assign sdo_oe  = cfg_out_en && (!cfg_two_wire || cfg_shared_tx);
    assign sclk_oe = cfg_master;
endmodule

// File: tb/test_ssi_shift_unit.sv
`timescale 1ns/1ps
module test_ssi_shift_unit;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_master = 1'b1, cfg_out_en = 1'b1, cfg_in_en = 1'b1;
    logic cfg_two_wire = 1'b0, cfg_shared_tx = 1'b0, cfg_edge_sel = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic wr_stb = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic sclk_in = 1'b1, sdo_in = 1'b1, sdi_in = 1'b1;
    logic sclk_out, sclk_oe, sdo_out, sdo_oe, busy, bus_busy, done;
    logic [7:0] rx_data;

    int n_chk = 0, n_bad = 0;

    ssi_shift_unit i_ssi_shift_unit (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_out_en(cfg_out_en),
        .cfg_in_en(cfg_in_en), .cfg_two_wire(cfg_two_wire), .cfg_shared_tx(cfg_shared_tx),
        .cfg_edge_sel(cfg_edge_sel), .cfg_div(cfg_div), .wr_stb(wr_stb), .wr_data(wr_data),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo_in(sdo_in),
        .sdo_out(sdo_out), .sdo_oe(sdo_oe), .sdi_in(sdi_in), .busy(busy),
        .bus_busy(bus_busy), .rx_data(rx_data), .done(done)
    );

    always #4 clk = !clk;

    // vector: [22] edge_sel, [21] two_wire, [20] shared_tx, [19:16] div, [15:8] tx, [7:0] peer
    localparam int NV = 6;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 4'd1, 8'hA5, 8'h3C},
        {1'b1, 1'b0, 1'b0, 4'd0, 8'h5A, 8'hC3},
        {1'b0, 1'b1, 1'b1, 4'd2, 8'h81, 8'hFF},
        {1'b1, 1'b1, 1'b0, 4'd3, 8'h7E, 8'h96},
        {1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 8'hFF},
        {1'b1, 1'b0, 1'b0, 4'd5, 8'hFF, 8'h00}
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic run_xfer(input bit slave, input bit es, input bit tw, input bit dir,
                            input logic [3:0] dv, input logic [7:0] tx, input logic [7:0] pr,
                            input int poke_t);
        logic [7:0] psh, cap;
        int ns, holdn, hold_bad, lown, falln, donen, done_bad, viol, oe_bad, t;
        bit pend, obs, prev_obs, prev_sdo, rise, fall, smp, lch, bb_first;
        int hh;
        logic [7:0] exp_rx;
        hh = 6;
        psh = pr; cap = 8'd0; pend = 1'b0;
        ns = 0; holdn = 0; hold_bad = 0; lown = 0; falln = 0; donen = 0;
        done_bad = 0; viol = 0; oe_bad = 0; t = 0; bb_first = 1'b0;
        exp_rx = (tw && dir) ? tx : pr;
        @(negedge clk);
        cfg_master = !slave; cfg_edge_sel = es; cfg_two_wire = tw;
        cfg_shared_tx = dir; cfg_div = {4'd0, dv};
        cfg_out_en = 1'b1; cfg_in_en = 1'b1;
        sclk_in = 1'b1;
        sdi_in = tw ? !psh[7] : psh[7];
        sdo_in = sdo_out;
        prev_obs = 1'b1; prev_sdo = sdo_out;
        wr_data = tx; wr_stb = 1'b1;
        while (t < 3000) begin
            @(negedge clk);
            wr_stb = (t + 1 == poke_t);
            if (t + 1 == poke_t) wr_data = 8'h11;
            if (t == 0) bb_first = bus_busy;
            if (slave)
                sclk_in = !((t >= 4) && (t < 4 + 16*hh) && ((((t - 4) / hh) % 2) == 0));
            obs = slave ? sclk_in : sclk_out;
            rise = obs && !prev_obs;
            fall = !obs && prev_obs;
            smp = es ? fall : rise;
            lch = es ? rise : fall;
            if (fall) falln++;
            if (smp) begin
                if (sdo_out != prev_sdo) viol++;
                cap = {cap[6:0], sdo_out};
                ns++;
                pend = (ns < 8);
            end else if (lch && pend) begin
                psh = {psh[6:0], 1'b1};
                pend = 1'b0;
            end
            sdi_in = tw ? !psh[7] : psh[7];
            sdo_in = sdo_oe ? sdo_out : psh[7];
            if (busy && sdo_oe != (!tw || dir)) oe_bad++;
            if (busy && !bus_busy) begin
                holdn++;
                if (sdo_out != tx[0]) hold_bad++;
            end
            if (!slave && !sclk_out) lown++;
            if (done) begin
                donen++;
                if (busy) done_bad++;
            end
            prev_obs = obs; prev_sdo = sdo_out;
            t++;
            if (donen > 0 && !busy && t > 4 + 16*hh*slave) break;
        end
        wr_stb = 1'b0;
        repeat (3) begin
            @(negedge clk);
            if (done) donen++;
        end
        chk(bb_first, "R12", "bus_busy after write", int'(bb_first), 1);
        chk(cap == tx, "R2", "bits seen on sdo_out", cap, tx);
        chk(rx_data == exp_rx, tw ? "R8" : "R7", "rx_data", rx_data, exp_rx);
        chk(viol == 0, "R3", "sdo_out moved at sample edge", viol, 0);
        chk(holdn == 2 * (dv + 1), slave ? "R11" : "R5", "hold cycles", holdn, 2 * (dv + 1));
        chk(hold_bad == 0, "R5", "last bit during hold", hold_bad, 0);
        chk(sdo_out == 1'b1, "R5", "sdo_out after hold", sdo_out, 1);
        chk(donen == 1 && done_bad == 0, "R6", "done pulses", donen, 1);
        chk(oe_bad == 0, "R8", "sdo_oe during transfer", oe_bad, 0);
        if (!slave) begin
            chk(lown == 8 * (dv + 1), "R4", "low half-period cycles", lown, 8 * (dv + 1));
            chk(falln == 8, "R4", "falling edges", falln, 8);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && bus_busy == 0 && done == 0, "R1", "flags at reset",
            {busy, bus_busy, done}, 0);
        chk(sclk_out == 1 && sdo_out == 1, "R1", "pins at reset", {sclk_out, sdo_out}, 3);
        chk(rx_data == 0, "R1", "rx_data at reset", rx_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++)
            run_xfer(1'b0, VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:16],
                     VEC[i][15:8], VEC[i][7:0], -1);

        // R11 slave, both edge selections
        run_xfer(1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 8'hB4, 8'h69, -1);
        run_xfer(1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 8'h2D, 8'hD2, -1);

        // R10 write during a transfer is ignored
        run_xfer(1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 8'hC3, 8'h4B, 12);

        // R9 forced abort in the middle of a master transfer
        keep = rx_data;
        @(negedge clk);
        cfg_master = 1'b1; cfg_two_wire = 1'b0; cfg_edge_sel = 1'b0; cfg_div = 8'd3;
        wr_data = 8'h3C; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (15) @(negedge clk);
        chk(bus_busy == 1, "R9", "transfer running before abort", bus_busy, 1);
        cfg_out_en = 1'b0; cfg_in_en = 1'b0;
        @(negedge clk);
        chk(busy == 0 && bus_busy == 0, "R9", "flags after abort", {busy, bus_busy}, 0);
        chk(sclk_out == 1, "R9", "sclk_out after abort", sclk_out, 1);
        chk(sdo_oe == 0, "R9", "sdo_oe after abort", sdo_oe, 0);
        begin
            int dn;
            dn = 0;
            repeat (40) begin
                @(negedge clk);
                if (done) dn++;
            end
            chk(dn == 0, "R9", "done after abort", dn, 0);
        end
        chk(rx_data == keep, "R9", "rx_data kept", rx_data, keep);

        // R10 write while aborted is ignored
        wr_data = 8'h55; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        begin
            int act;
            act = 0;
            repeat (10) begin
                @(negedge clk);
                if (busy || !sclk_out) act++;
            end
            chk(act == 0, "R10", "activity after write while aborted", act, 0);
        end
        cfg_out_en = 1'b1; cfg_in_en = 1'b1;

        // recovery after abort
        run_xfer(1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 8'h96, 8'h0F, -1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule